// File: doc/BRIEF.md
# Byte-Swap and Sign-Extend Unit

A purely combinational execution unit for a 64-bit integer pipeline. It takes a 32-bit instruction word and one 64-bit source operand and, when the word is one of five register-to-register permute or extend operations, gives the 64-bit result together with the destination register index and a valid flag.

The operations are selected by a function code in the low six bits and by a sub-operation code in bits 10:6 under a single major opcode. There are five of them:
- a byte swap inside every 16-bit halfword of the full doubleword
- a reversal of halfword order
- a byte swap inside the two halfwords of the low word, sign-extended to 64 bits
- sign extension of the low byte
- sign extension of the low halfword

Every other encoding is reported as not recognised, with a zero result. Raising an exception for it is left to the surrounding pipeline.

Register reads and writes, hazard handling and privilege checks sit outside this unit. The source operand arrives already read, and the caller uses the destination index only when valid is high.

Top module: `bswx_unit`

## Requirements
- R1: An encoding is recognised only when bits 31:26 equal 011111 and bits 25:21 equal 00000. The function code sits in bits 5:0 and the sub-operation in bits 10:6.
- R2: Function 100100 with sub-operation 00010 exchanges the two bytes of each of the four 16-bit halfwords of the operand.
- R3: Function 100100 with sub-operation 00101 reverses halfword order: result halfword k equals operand halfword 3-k, with the byte order inside each halfword unchanged.
- R4: Function 100000 with sub-operation 00010 exchanges the bytes of each halfword in operand bits 31:0. It then fills result bits 63:32 with result bit 31.
- R5: Function 100000 with sub-operation 10000 returns operand bits 7:0, with every higher result bit equal to operand bit 7.
- R6: Function 100000 with sub-operation 11000 returns operand bits 15:0, with every higher result bit equal to operand bit 15.
- R7: For any encoding not listed in R2 to R6 (wrong opcode, nonzero bits 25:21, other function or sub-operation), valid is 0 and the result is all zeros, whatever the operand.
- R8: Valid is 1 for the five encodings of R2 to R6. The destination index always equals instruction bits 15:11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| srcOperand | input | 64 | Source register value, already read |
| result | output | 64 | Operation result, zero when not recognised |
| destIdx | output | 5 | Destination register index, bits 15:11 |
| resultValid | output | 1 | High when the encoding is one of the five operations |

## Verification
The assertions assume that the instruction word and the operand are settled, two-state values at the time each combinational block evaluates, and that only the decoder drives the strobe struct. The bench holds each input pair stable for a full clock period and changes inputs only on the falling edge. It samples a nanosecond later, so no check sees a half-updated input pair. The stimulus covers every recognised encoding, encodings that differ from a valid one in a single field, and operands with the sign bit set at bit 7, bit 15 and bit 31, alone and together.

// File: rtl/bswx_pkg.sv
`timescale 1ns/1ps
package bswx_pkg;
  localparam int WORD_W   = 64;
  localparam int INSTR_W  = 32;
  localparam int REG_IDX_W = 5;

  localparam logic [5:0] MAJOR_OP   = 6'b011111;
  localparam logic [5:0] FN_PERMUTE = 6'b100100;
  localparam logic [5:0] FN_EXTEND  = 6'b100000;
  localparam logic [4:0] SUB_SWAP   = 5'b00010;
  localparam logic [4:0] SUB_HREV   = 5'b00101;
  localparam logic [4:0] SUB_SEXTB  = 5'b10000;
  localparam logic [4:0] SUB_SEXTH  = 5'b11000;

  typedef struct packed {
    logic swapAll;
    logic halfRev;
    logic swapLow;
    logic sextByte;
    logic sextHalf;
  } ctrlStrobes_t;
endpackage

// File: rtl/bswx_decode.sv
`timescale 1ns/1ps
module bswx_decode
  import bswx_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W,
  parameter int IDX_WIDTH   = REG_IDX_W
) (
  input  logic [INSTR_WIDTH-1:0] instrWord,
  output ctrlStrobes_t           strobes,
  output logic [IDX_WIDTH-1:0]   destIdx,
  output logic                   opValid
);
  logic [5:0] majorOp;
  logic [4:0] rsField;
  logic [4:0] subOp;
  logic [5:0] funcCode;
  logic       classHit;

  assign majorOp  = instrWord[31:26];
  assign rsField  = instrWord[25:21];
  assign subOp    = instrWord[10:6];
  assign funcCode = instrWord[5:0];
  assign destIdx  = instrWord[15:11];
  assign classHit = (majorOp == MAJOR_OP) && (rsField == '0);

  always_comb begin
    strobes = '0;
    if (classHit) begin
      if (funcCode == FN_PERMUTE) begin
        strobes.swapAll = (subOp == SUB_SWAP);
        strobes.halfRev = (subOp == SUB_HREV);
      end else if (funcCode == FN_EXTEND) begin
        strobes.swapLow  = (subOp == SUB_SWAP);
        strobes.sextByte = (subOp == SUB_SEXTB);
        strobes.sextHalf = (subOp == SUB_SEXTH);
      end
    end
  end

  assign opValid = |strobes;

  always_comb begin
    // R7: never more than one operation selected
    p_single_op_r7: assert ($onehot0(strobes));
    // R1: a recognised encoding carries the right opcode and a zero rs field
    p_valid_fields_r1: assert (!opValid || (instrWord[31:26] == 6'b011111 && instrWord[25:21] == 5'b0));
  end
endmodule

// File: rtl/bswx_permute.sv
`timescale 1ns/1ps
module bswx_permute
  import bswx_pkg::*;
#(
  parameter int DATA_WIDTH = WORD_W
) (
  input  ctrlStrobes_t          strobes,
  input  logic [DATA_WIDTH-1:0] srcOperand,
  output logic [DATA_WIDTH-1:0] result
);
  localparam int HALF_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int LOW_W    = 32;
  localparam int HALF_CNT = DATA_WIDTH / HALF_W;

  logic [DATA_WIDTH-1:0] swapAllVal;
  logic [DATA_WIDTH-1:0] halfRevVal;
  logic [DATA_WIDTH-1:0] swapLowVal;
  logic [DATA_WIDTH-1:0] sextByteVal;
  logic [DATA_WIDTH-1:0] sextHalfVal;

  for (genvar h = 0; h < HALF_CNT; h++) begin : g_half
    assign swapAllVal[h*HALF_W +: HALF_W] =
      {srcOperand[h*HALF_W +: BYTE_W], srcOperand[h*HALF_W+BYTE_W +: BYTE_W]};
    assign halfRevVal[h*HALF_W +: HALF_W] =
      srcOperand[(HALF_CNT-1-h)*HALF_W +: HALF_W];
  end

  assign swapLowVal  = {{(DATA_WIDTH-LOW_W){swapAllVal[LOW_W-1]}}, swapAllVal[LOW_W-1:0]};
  assign sextByteVal = {{(DATA_WIDTH-BYTE_W){srcOperand[BYTE_W-1]}}, srcOperand[BYTE_W-1:0]};
  assign sextHalfVal = {{(DATA_WIDTH-HALF_W){srcOperand[HALF_W-1]}}, srcOperand[HALF_W-1:0]};

  always_comb begin
    result = '0;
    if (strobes.swapAll)  result = swapAllVal;
    if (strobes.halfRev)  result = halfRevVal;
    if (strobes.swapLow)  result = swapLowVal;
    if (strobes.sextByte) result = sextByteVal;
    if (strobes.sextHalf) result = sextHalfVal;
  end

  always_comb begin
    // R5: the bits above the byte copy its sign
    p_byte_fill_r5: assert (!strobes.sextByte || result[DATA_WIDTH-1:BYTE_W] == {(DATA_WIDTH-BYTE_W){srcOperand[BYTE_W-1]}});
    // R6: the bits above the halfword copy its sign
    p_half_fill_r6: assert (!strobes.sextHalf || result[DATA_WIDTH-1:HALF_W] == {(DATA_WIDTH-HALF_W){srcOperand[HALF_W-1]}});
    // R4: the upper word copies the sign of the swapped low word, which comes from operand bit 23
    p_low_fill_r4: assert (!strobes.swapLow || result[DATA_WIDTH-1:LOW_W] == {(DATA_WIDTH-LOW_W){srcOperand[23]}});
    // R7: no strobe, zero result
    p_idle_zero_r7: assert (strobes != '0 || result == '0);
    // R3: the top halfword lands at the bottom
    p_rev_ends_r3: assert (!strobes.halfRev || result[HALF_W-1:0] == srcOperand[DATA_WIDTH-1 -: HALF_W]);
    // R2: the bytes of every halfword trade places
    p_swap_bytes_r2: assert (!strobes.swapAll || {result[7:0], result[15:8]} == srcOperand[15:0]);
  end
endmodule

// File: rtl/bswx_unit.sv
`timescale 1ns/1ps
module bswx_unit
  import bswx_pkg::*;
(
  input  logic [31:0] instrWord,
  input  logic [63:0] srcOperand,
  output logic [63:0] result,
  output logic [4:0]  destIdx,
  output logic        resultValid
);
  ctrlStrobes_t strobes;

  bswx_decode #(
    .INSTR_WIDTH(INSTR_W),
    .IDX_WIDTH(REG_IDX_W)
  ) u_decode (
    .instrWord(instrWord),
    .strobes(strobes),
    .destIdx(destIdx),
    .opValid(resultValid)
  );

  bswx_permute #(
    .DATA_WIDTH(WORD_W)
  ) u_permute (
    .strobes(strobes),
    .srcOperand(srcOperand),
    .result(result)
  );

  always_comb begin
    // R8: the destination index follows the instruction word
    p_dest_follow_r8: assert (destIdx == instrWord[15:11]);
  end
endmodule

// File: tb/bswx_unit_bench.sv
`timescale 1ns/1ps
module bswx_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] srcOperand = '0;
  logic [63:0] result;
  logic [4:0]  destIdx;
  logic        resultValid;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bswx_unit u_bswx_unit (
    .instrWord(instrWord),
    .srcOperand(srcOperand),
    .result(result),
    .destIdx(destIdx),
    .resultValid(resultValid)
  );

  function automatic logic [31:0] mkInstr(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [4:0] sa, logic [5:0] fn);
    return {op, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [63:0] refSwap(logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 8; i++) y[8*(i^1) +: 8] = x[8*i +: 8];
    return y;
  endfunction

  function automatic logic [63:0] refRev(logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 4; i++) y[16*(3-i) +: 16] = x[16*i +: 16];
    return y;
  endfunction

  function automatic logic [63:0] refLow(logic [63:0] x);
    logic [63:0] s;
    s = refSwap(x);
    return 64'($signed(s[31:0]));
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] iw, logic [63:0] op);
    @(negedge clk);
    instrWord = iw;
    srcOperand = op;
    #1;
  endtask

  task automatic runOp(string req, logic [5:0] fn, logic [4:0] sa, logic [63:0] op, logic [63:0] exp);
    logic [4:0] rd;
    rd = 5'(op[4:0] ^ 5'd9);
    apply(mkInstr(6'b011111, 5'd0, 5'd3, rd, sa, fn), op);
    check(req, "result", result, exp);
    check("R8", "valid", 64'(resultValid), 64'd1);
    check("R8", "dest", 64'(destIdx), 64'(rd));
  endtask

  task automatic runInvalid(string what, logic [31:0] iw, logic [63:0] op);
    apply(iw, op);
    check("R7", {what, " valid"}, 64'(resultValid), 64'd0);
    check("R7", {what, " result"}, result, 64'd0);
    check("R8", {what, " dest"}, 64'(destIdx), 64'(iw[15:11]));
  endtask

  task automatic testReset();
    check("R7", "reset valid", 64'(resultValid), 64'd0);
    check("R7", "reset result", result, 64'd0);
  endtask

  task automatic testSwapAll(logic [63:0] op);
    runOp("R2", 6'b100100, 5'b00010, op, refSwap(op));
  endtask

  task automatic testHalfRev(logic [63:0] op);
    runOp("R3", 6'b100100, 5'b00101, op, refRev(op));
  endtask

  task automatic testSwapLow(logic [63:0] op);
    runOp("R4", 6'b100000, 5'b00010, op, refLow(op));
  endtask

  task automatic testSextByte(logic [63:0] op);
    runOp("R5", 6'b100000, 5'b10000, op, 64'($signed(op[7:0])));
  endtask

  task automatic testSextHalf(logic [63:0] op);
    runOp("R6", 6'b100000, 5'b11000, op, 64'($signed(op[15:0])));
  endtask

  task automatic testInvalids();
    logic [63:0] op;
    op = 64'hFFFF_8080_8000_8080;
    runInvalid("R1 opcode", mkInstr(6'b011110, 5'd0, 5'd1, 5'd2, 5'b00010, 6'b100100), op);
    runInvalid("R1 rs", mkInstr(6'b011111, 5'd1, 5'd1, 5'd2, 5'b00010, 6'b100100), op);
    runInvalid("subop", mkInstr(6'b011111, 5'd0, 5'd1, 5'd7, 5'b00101, 6'b100000), op);
    runInvalid("subop2", mkInstr(6'b011111, 5'd0, 5'd1, 5'd7, 5'b10000, 6'b100100), op);
    runInvalid("func", mkInstr(6'b011111, 5'd0, 5'd1, 5'd31, 5'b00010, 6'b100101), op);
    runInvalid("zero sa", mkInstr(6'b011111, 5'd0, 5'd1, 5'd4, 5'b00000, 6'b100000), op);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [6];
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'h0000_0000_0000_0080;
    pats[2] = 64'h0000_0000_0000_8000;
    pats[3] = 64'h0000_0000_8000_0000;
    pats[4] = 64'h7F7F_7F7F_0080_007F;
    pats[5] = 64'hDEAD_BEEF_CAFE_F00D;
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      testSwapAll(pats[i]);
      testHalfRev(pats[i]);
      testSwapLow(pats[i]);
      testSextByte(pats[i]);
      testSextHalf(pats[i]);
    end
    testSwapLow(64'h0000_0000_0080_0000);
    testSextByte(64'hFFFF_FFFF_FFFF_FF7F);
    testSextHalf(64'hFFFF_FFFF_FFFF_7FFF);
    for (int i = 0; i < 20; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      testSwapAll(r);
      testHalfRev(r);
      testSwapLow(r);
      testSextByte(r);
      testSextHalf(r);
    end
    testInvalids();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule